// File: doc/BRIEF.md
# Boot-Strapped ROM Window Controller

This block owns the top 32 KiB of a 24-bit byte address space and decides, per request, whether that window is served by an on-chip read-only store or handed to external memory. A mode bit picks the route. It is loaded from three boot-mode pins once per hardware reset, and software may rewrite it later. A software reset leaves it alone.

Three requesters share the store: program fetch (port 0), data (port 1) and DMA (port 2). A fixed-priority arbiter picks one ROM read at a time. A wait-state sequencer then raises that port's `ready_o` together with the read word. An isolated read costs three cycles. A read that directly continues the previous one costs two. Every request that is not a ROM access is flagged on `ext_sel_o`, and its address is copied to `ext_addr_o` unchanged.

Top module: `rom_window_ctrl`

## Requirements
- R1: The mode bit is loaded on the first clock edge after the internally synchronised release of `rst_n`. It becomes 1 when `boot_mode_i` is 3'b000 and 0 for any other pattern. It reads 1 while reset is active and until that load. Later pin changes have no effect until the next hardware reset.
- R2: A one-cycle pulse on `sw_rst_i` aborts a ROM read in progress without raising `ready_o`, and it forgets the burst history. `mode_o` keeps its value.
- R3: After strap load, `mode_we_i` high at a clock edge loads `mode_wd_i` into the mode bit, and `mode_o` shows the new value from the next cycle. Value 1 disables the ROM and value 0 enables it.
- R4: A byte address is inside the window when bits 23:15 are all ones (FF8000h to FFFFFFh). A request outside the window, or inside it while the mode bit is 1, raises `ext_sel_o` for that port in the same cycle. It also copies the address to `ext_addr_o` and keeps `ready_o` low.
- R5: A write (`we_i`=1) inside the window while the ROM is enabled is dropped. `ready_o` is high and `ext_sel_o` is low in the same cycle, and no ROM read starts.
- R6: A ROM read that does not qualify under R7 raises `ready_o` in the third cycle, counting the cycle in which the request is granted as the first.
- R7: A read is a follow-on, and raises `ready_o` in its second cycle, only if all of these hold: it is granted in the cycle right after the previous ROM read's ready cycle, it comes from the same port, and its byte address is the previous one plus 2. A different port, a different address, or one idle cycle in between gives the R6 cost.
- R8: Grants happen only while no ROM read is in progress. Among pending ROM reads, port 2 wins over port 1, and port 1 wins over port 0. A waiting port holds `ready_o` low, and at most one read port sees `ready_o` in a cycle.
- R9: In a ROM read's ready cycle, `rdata_o` of the owning port equals `{k, 2'b01} XOR 16'hC3A5`, where k is byte-address bits 14:1. In every other cycle `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| boot_mode_i | input | 3 | Boot-mode pins, sampled once after hardware reset |
| sw_rst_i | input | 1 | Software reset pulse, synchronous |
| mode_we_i | input | 1 | Status-register write strobe for the mode bit |
| mode_wd_i | input | 1 | Value written to the mode bit |
| mode_o | output | 1 | Current mode bit (1 = ROM off) |
| req_i | input | 3 | Request per port (0 program, 1 data, 2 DMA), held until ready |
| we_i | input | 3 | Write flag per port |
| addr_i | input | 3x24 | Byte address per port |
| ready_o | output | 3 | Completion per port |
| ext_sel_o | output | 3 | Request routed to external memory, per port |
| ext_addr_o | output | 3x24 | Address passed to external memory, per port |
| rdata_o | output | 3x16 | ROM read word per port |

## Verification
Single isolated reads and unbroken four-word runs from one port separate the three-cycle cost from the two-cycle cost. Runs broken by one idle cycle, and a continuation at the next address taken over by a different port, show that the follow-on rule checks timing, port and address together. Three ports asserting at once show the grant order through their completion times of 3, 6 and 9 cycles. Out-of-window reads, window reads with the mode bit set, and dropped window writes separate external routing from ROM service. Hardware resets with zero and non-zero pin patterns, a software-reset pulse during a read, and status writes show which events may change the mode bit.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  localparam int unsigned PORT_PROG = 0;
  localparam int unsigned PORT_DATA = 1;
  localparam int unsigned PORT_DMA  = 2;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rwc_reset_sync.sv
module rwc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rwc_mode_reg.sv
module rwc_mode_reg #(
  parameter int unsigned BOOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BOOT_W-1:0] boot_i,
  input  logic              wr_en_i,
  input  logic              wr_val_i,
  output logic              mode_o,
  output logic              strap_done_o
);
  logic mode_q, mode_d;
  logic done_q, done_d;

  // The pins are looked at exactly once: on the first edge out of reset.
  always_comb begin
    mode_d = mode_q;
    done_d = 1'b1;
    if (!done_q)      mode_d = (boot_i == '0);
    else if (wr_en_i) mode_d = wr_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      done_q <= done_d;
    end
  end

  assign mode_o       = mode_q;
  assign strap_done_o = done_q;
endmodule

// File: rtl/rwc_prio_arb.sv
module rwc_prio_arb #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // Highest index wins.
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && !found) begin
        found = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rwc_rom_seq.sv
module rwc_rom_seq #(
  parameter int unsigned WAW       = 23,
  parameter int unsigned OUT_W     = 14,
  parameter int unsigned IW        = 2,
  parameter int unsigned FIRST_LAT = 3,
  parameter int unsigned NEXT_LAT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst_i,
  input  logic             start_i,
  input  logic [IW-1:0]    start_idx_i,
  input  logic [WAW-1:0]   start_waddr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IW-1:0]    owner_o,
  output logic [OUT_W-1:0] waddr_o
);
  localparam int unsigned MAX_LAT = (FIRST_LAT > NEXT_LAT) ? FIRST_LAT : NEXT_LAT;
  localparam int unsigned CW      = $clog2(MAX_LAT + 1);

  logic           busy_q, busy_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [IW-1:0]  own_q, own_d;
  logic [WAW-1:0] wa_q, wa_d;
  logic           hv_q, hv_d;
  logic [IW-1:0]  hown_q, hown_d;
  logic [WAW-1:0] hwa_q, hwa_d;
  logic           follow;

  assign done_o = busy_q && (cnt_q == CW'(1));
  assign follow = hv_q && (hown_q == start_idx_i) &&
                  (start_waddr_i == WAW'(hwa_q + 1'b1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    own_d  = own_q;
    wa_d   = wa_q;
    hv_d   = hv_q;
    hown_d = hown_q;
    hwa_d  = hwa_q;
    if (sw_rst_i) begin
      busy_d = 1'b0;
      hv_d   = 1'b0;
    end else if (busy_q) begin
      if (done_o) begin
        busy_d = 1'b0;
        hv_d   = 1'b1;
        hown_d = own_q;
        hwa_d  = wa_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      own_d  = start_idx_i;
      wa_d   = start_waddr_i;
      cnt_d  = follow ? CW'(NEXT_LAT - 1) : CW'(FIRST_LAT - 1);
    end else begin
      hv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      own_q  <= '0;
      wa_q   <= '0;
      hv_q   <= 1'b0;
      hown_q <= '0;
      hwa_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      own_q  <= own_d;
      wa_q   <= wa_d;
      hv_q   <= hv_d;
      hown_q <= hown_d;
      hwa_q  <= hwa_d;
    end
  end

  assign busy_o  = busy_q;
  assign owner_o = own_q;
  assign waddr_o = wa_q[OUT_W-1:0];
endmodule

// File: rtl/rwc_rom_data.sv
module rwc_rom_data #(
  parameter int unsigned RAW  = 14,
  parameter int unsigned DW   = 16,
  parameter logic [DW-1:0] SEED = 16'hC3A5
) (
  input  logic [RAW-1:0] waddr_i,
  output logic [DW-1:0]  data_o
);
  // Contents are a closed-form function of the word index.
  logic [RAW+1:0] raw;
  assign raw    = {waddr_i, 2'b01};
  assign data_o = DW'(raw) ^ SEED;
endmodule

// File: rtl/rom_window_ctrl.sv
module rom_window_ctrl #(
  parameter int unsigned NPORT     = 3,
  parameter int unsigned AW        = 24,
  parameter int unsigned DW        = 16,
  parameter int unsigned WIN_LSB   = 15,
  parameter int unsigned BOOT_W    = 3,
  parameter int unsigned FIRST_LAT = 3,
  parameter int unsigned NEXT_LAT  = 2,
  parameter int unsigned SYNC_STG  = 2,
  parameter logic [DW-1:0] ROM_SEED = 16'hC3A5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [BOOT_W-1:0]             boot_mode_i,
  input  logic                          sw_rst_i,
  input  logic                          mode_we_i,
  input  logic                          mode_wd_i,
  output logic                          mode_o,
  input  logic [NPORT-1:0]              req_i,
  input  logic [NPORT-1:0]              we_i,
  input  logic [NPORT-1:0][AW-1:0]      addr_i,
  output logic [NPORT-1:0]              ready_o,
  output logic [NPORT-1:0]              ext_sel_o,
  output logic [NPORT-1:0][AW-1:0]      ext_addr_o,
  output logic [NPORT-1:0][DW-1:0]      rdata_o
);
  localparam int unsigned IW  = rwc_pkg::idx_width(NPORT);
  localparam int unsigned WAW = AW - 1;
  localparam int unsigned RAW = WIN_LSB - 1;

  logic             rst_core_n;
  logic             mode;
  logic             strap_done;
  logic [NPORT-1:0] in_win;
  logic [NPORT-1:0] rd_req;
  logic [NPORT-1:0] wr_drop;
  logic [NPORT-1:0] arb_req;
  logic             arb_any;
  logic [IW-1:0]    arb_idx;
  logic             seq_busy;
  logic             seq_done;
  logic [IW-1:0]    seq_owner;
  logic [RAW-1:0]   seq_waddr;
  logic [WAW-1:0]   start_waddr;
  logic [DW-1:0]    rom_word;

  rwc_reset_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  rwc_mode_reg #(.BOOT_W(BOOT_W)) u_mode (
    .clk(clk), .rst_n(rst_core_n), .boot_i(boot_mode_i),
    .wr_en_i(mode_we_i), .wr_val_i(mode_wd_i),
    .mode_o(mode), .strap_done_o(strap_done)
  );

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign in_win[p]     = &addr_i[p][AW-1:WIN_LSB];
      assign ext_sel_o[p]  = req_i[p] && (!in_win[p] || mode);
      assign wr_drop[p]    = req_i[p] && we_i[p] && in_win[p] && !mode;
      assign rd_req[p]     = req_i[p] && !we_i[p] && in_win[p] && !mode;
      assign ext_addr_o[p] = addr_i[p];
      assign ready_o[p]    = wr_drop[p] || (seq_done && (seq_owner == IW'(p)));
      assign rdata_o[p]    = (seq_done && (seq_owner == IW'(p))) ? rom_word : '0;
    end
  endgenerate

  assign arb_req     = rd_req & {NPORT{~seq_busy}};
  assign start_waddr = addr_i[arb_idx][AW-1:1];

  rwc_prio_arb #(.N(NPORT), .IW(IW)) u_arb (
    .req_i(arb_req), .any_o(arb_any), .idx_o(arb_idx)
  );

  rwc_rom_seq #(
    .WAW(WAW), .OUT_W(RAW), .IW(IW),
    .FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT)
  ) u_seq (
    .clk(clk), .rst_n(rst_core_n), .sw_rst_i(sw_rst_i),
    .start_i(arb_any), .start_idx_i(arb_idx), .start_waddr_i(start_waddr),
    .busy_o(seq_busy), .done_o(seq_done), .owner_o(seq_owner), .waddr_o(seq_waddr)
  );

  rwc_rom_data #(.RAW(RAW), .DW(DW), .SEED(ROM_SEED)) u_rom (
    .waddr_i(seq_waddr), .data_o(rom_word)
  );

  assign mode_o = mode;
endmodule

// File: rtl/rom_window_ctrl_chk.sv
module rom_window_ctrl_chk #(
  parameter int unsigned NPORT   = 3,
  parameter int unsigned AW      = 24,
  parameter int unsigned DW      = 16,
  parameter int unsigned WIN_LSB = 15
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mode_we_i,
  input logic                     mode_o,
  input logic                     strap_done_i,
  input logic [NPORT-1:0]         req_i,
  input logic [NPORT-1:0]         we_i,
  input logic [NPORT-1:0][AW-1:0] addr_i,
  input logic [NPORT-1:0]         ready_o,
  input logic [NPORT-1:0]         ext_sel_o,
  input logic [NPORT-1:0][AW-1:0] ext_addr_o,
  input logic [NPORT-1:0][DW-1:0] rdata_o
);
  logic [NPORT-1:0] rd_ready;
  assign rd_ready = ready_o & ~we_i;

  AST_ONE_ROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_ready)); // R8

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_ready) |=> !(|rd_ready)); // R7

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done_i && !mode_we_i) |=> $stable(mode_o)); // R2

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_chk
      AST_WR_DROP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i[p] && we_i[p] && (&addr_i[p][AW-1:WIN_LSB]) && !mode_o)
          |-> (ready_o[p] && !ext_sel_o[p])); // R5

      AST_EXT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel_o[p] |-> (!ready_o[p] && (ext_addr_o[p] == addr_i[p]))); // R4

      AST_READ_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready[p] |-> $past(req_i[p])); // R6

      AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o[p] |-> (rdata_o[p] == '0)); // R9
    end
  endgenerate
endmodule

bind rom_window_ctrl rom_window_ctrl_chk #(
  .NPORT(NPORT), .AW(AW), .DW(DW), .WIN_LSB(WIN_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_we_i(mode_we_i), .mode_o(mode_o),
  .strap_done_i(strap_done), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .ready_o(ready_o), .ext_sel_o(ext_sel_o), .ext_addr_o(ext_addr_o),
  .rdata_o(rdata_o)
);

// File: tb/rom_window_ctrl_bench.sv
`timescale 1ns/1ps
module rom_window_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NP    = 3;
  localparam int AW    = 24;
  localparam int DW    = 16;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic                   rst_n;
  logic [2:0]             boot_mode_i;
  logic                   sw_rst_i, mode_we_i, mode_wd_i, mode_o;
  logic [NP-1:0]          req_i, we_i, ready_o, ext_sel_o;
  logic [NP-1:0][AW-1:0]  addr_i, ext_addr_o;
  logic [NP-1:0][DW-1:0]  rdata_o;

  rom_window_ctrl u_rom_window_ctrl (
    .clk(clk), .rst_n(rst_n), .boot_mode_i(boot_mode_i), .sw_rst_i(sw_rst_i),
    .mode_we_i(mode_we_i), .mode_wd_i(mode_wd_i), .mode_o(mode_o),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .ready_o(ready_o),
    .ext_sel_o(ext_sel_o), .ext_addr_o(ext_addr_o), .rdata_o(rdata_o)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rom_fn(input logic [23:0] a);
    logic [13:0] k;
    k = a[14:1];
    return {k, 2'b01} ^ 16'hC3A5;
  endfunction

  function automatic bit win(input logic [23:0] a);
    return &a[23:15];
  endfunction

  // ---------------- behavioural reference model ----------------
  int          m_sync, m_cnt, m_own, m_hp;
  bit          m_mode, m_busy, m_hv;
  logic [22:0] m_wa, m_hwa;

  task automatic m_reset();
    m_sync = 0; m_mode = 1'b1; m_busy = 1'b0; m_hv = 1'b0; m_cnt = 0;
  endtask

  task automatic m_step();
    int g;
    bit follow;
    if (m_sync >= 2) begin
      if (sw_rst_i) begin
        m_busy = 1'b0; m_hv = 1'b0;
      end else if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy = 1'b0; m_hv = 1'b1; m_hp = m_own; m_hwa = m_wa;
        end else m_cnt--;
      end else begin
        g = -1;
        for (int p = NP - 1; p >= 0; p--)
          if (g < 0 && req_i[p] && !we_i[p] && win(addr_i[p]) && !m_mode) g = p;
        if (g >= 0) begin
          follow = m_hv && (m_hp == g) && (addr_i[g][23:1] == 23'(m_hwa + 1));
          m_busy = 1'b1; m_own = g; m_wa = addr_i[g][23:1];
          m_cnt = follow ? 1 : 2;
        end else m_hv = 1'b0;
      end
      if (m_sync == 2)    m_mode = (boot_mode_i == 3'b000);
      else if (mode_we_i) m_mode = mode_wd_i;
    end
    if (m_sync < 3) m_sync++;
  endtask

  task automatic m_compare();
    bit ext_e, wr_e, rr_e;
    logic [15:0] rd_e;
    chk(mode_o === m_mode, "R1/R3", "mode_o", mode_o, m_mode);
    for (int p = 0; p < NP; p++) begin
      ext_e = req_i[p] && (!win(addr_i[p]) || m_mode);
      wr_e  = req_i[p] && we_i[p] && win(addr_i[p]) && !m_mode;
      rr_e  = m_busy && (m_cnt == 1) && (m_own == p);
      rd_e  = rr_e ? rom_fn({m_wa, 1'b0}) : 16'h0;
      chk(ext_sel_o[p] === ext_e, "R4", $sformatf("ext_sel[%0d]", p), ext_sel_o[p], ext_e);
      if (ext_e)
        chk(ext_addr_o[p] === addr_i[p], "R4", $sformatf("ext_addr[%0d]", p),
            ext_addr_o[p], addr_i[p]);
      chk(ready_o[p] === (wr_e || rr_e), wr_e ? "R5" : "R6/R7/R8",
          $sformatf("ready[%0d]", p), ready_o[p], wr_e || rr_e);
      chk(rdata_o[p] === rd_e, "R9", $sformatf("rdata[%0d]", p), rdata_o[p], rd_e);
    end
  endtask

  initial begin
    m_reset();
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (!rst_n) m_reset();
      m_compare();
      @(posedge clk);
      if (!rst_n) m_reset();
      else        m_step();
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- directed helpers ----------------
  task automatic wait_ready(input int p, output int cyc);
    bit got;
    cyc = 0;
    got = 1'b0;
    while (!got) begin
      #(CLK_P/4);
      cyc++;
      got = ready_o[p];
      if (!got) @(negedge clk);
    end
  endtask

  task automatic rd_run(input int p, input logic [23:0] base, input int n,
                        input bit gap, input int first_exp, input string tag);
    int cyc, exp;
    logic [23:0] a;
    for (int i = 0; i < n; i++) begin
      a = base + 24'(2 * i);
      addr_i[p] = a; we_i[p] = 1'b0; req_i[p] = 1'b1;
      wait_ready(p, cyc);
      exp = (i == 0) ? first_exp : (gap ? 3 : 2);
      chk(cyc == exp, tag, $sformatf("latency port%0d word%0d", p, i), cyc, exp);
      chk(rdata_o[p] == rom_fn(a), "R9", "rom word", rdata_o[p], rom_fn(a));
      @(negedge clk);
      if (gap && i < n - 1) begin
        req_i[p] = 1'b0;
        @(negedge clk);
      end
    end
    req_i[p] = 1'b0;
  endtask

  task automatic set_mode(input bit v);
    @(negedge clk);
    mode_we_i = 1'b1; mode_wd_i = v;
    @(negedge clk);
    mode_we_i = 1'b0;
    #(CLK_P/4);
    chk(mode_o == v, "R3", "mode after write", mode_o, v);
  endtask

  task automatic hw_reset(input logic [2:0] pins);
    @(negedge clk);
    rst_n = 1'b0; boot_mode_i = pins;
    repeat (2) @(negedge clk);
    #(CLK_P/4);
    chk(mode_o == 1'b1, "R1", "mode during reset", mode_o, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int cyc;
    bit m0;
    rst_n = 1'b0; boot_mode_i = 3'b010; sw_rst_i = 1'b0;
    mode_we_i = 1'b0; mode_wd_i = 1'b0;
    req_i = '0; we_i = '0; addr_i = '0;

    hw_reset(3'b010);
    #(CLK_P/4);
    chk(mode_o == 1'b0, "R1", "strap 010 enables ROM", mode_o, 0);
    boot_mode_i = 3'b000;
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    chk(mode_o == 1'b0, "R1", "pins ignored after reset", mode_o, 0);
    @(negedge clk);

    // R6 isolated read, R9 data
    rd_run(0, 24'hFF8000, 1, 1'b0, 3, "R6");
    // R7 unbroken run of four words
    rd_run(1, 24'hFFA000, 4, 1'b0, 3, "R7");
    // R7 next address but a different port pays full cost
    rd_run(0, 24'hFFA008, 1, 1'b0, 3, "R7");
    // R7 idle cycle between words pays full cost
    rd_run(2, 24'hFFA100, 3, 1'b1, 3, "R7");

    // R8 three ports at once
    @(negedge clk);
    fork
      rd_run(2, 24'hFFB000, 1, 1'b0, 3, "R8");
      rd_run(1, 24'hFFC000, 1, 1'b0, 6, "R8");
      rd_run(0, 24'hFFD000, 1, 1'b0, 9, "R8");
    join
    @(negedge clk);

    // R5 dropped write
    req_i[1] = 1'b1; we_i[1] = 1'b1; addr_i[1] = 24'hFF9000;
    #(CLK_P/4);
    chk(ready_o[1] == 1'b1, "R5", "write ready same cycle", ready_o[1], 1);
    chk(ext_sel_o[1] == 1'b0, "R5", "write not external", ext_sel_o[1], 0);
    @(negedge clk);
    req_i[1] = 1'b0; we_i[1] = 1'b0;
    @(negedge clk);

    // R4 out-of-window read
    req_i[0] = 1'b1; addr_i[0] = 24'h001234;
    #(CLK_P/4);
    chk(ext_sel_o[0] == 1'b1, "R4", "outside window external", ext_sel_o[0], 1);
    chk(ext_addr_o[0] == 24'h001234, "R4", "address passthrough", ext_addr_o[0], 24'h001234);
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    chk(ready_o[0] == 1'b0, "R4", "no ready on external", ready_o[0], 0);
    @(negedge clk);
    req_i[0] = 1'b0;

    // R3 mode write disables ROM
    set_mode(1'b1);
    @(negedge clk);
    req_i[2] = 1'b1; addr_i[2] = 24'hFF8020;
    #(CLK_P/4);
    chk(ext_sel_o[2] == 1'b1, "R3", "window external when off", ext_sel_o[2], 1);
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    chk(ready_o[2] == 1'b0, "R3", "no ROM read when off", ready_o[2], 0);
    @(negedge clk);
    req_i[2] = 1'b0;
    set_mode(1'b0);
    @(negedge clk);

    // R2 software reset aborts a read, mode untouched
    req_i[0] = 1'b1; addr_i[0] = 24'hFF8010;
    @(negedge clk);
    sw_rst_i = 1'b1; m0 = mode_o;
    @(negedge clk);
    sw_rst_i = 1'b0;
    wait_ready(0, cyc);
    chk(cyc == 3, "R2", "restart after abort", cyc, 3);
    chk(mode_o == m0, "R2", "mode kept by soft reset", mode_o, m0);
    @(negedge clk);
    req_i[0] = 1'b0;

    // R1 all-zero strap disables ROM
    hw_reset(3'b000);
    #(CLK_P/4);
    chk(mode_o == 1'b1, "R1", "strap 000 disables ROM", mode_o, 1);
    @(negedge clk);
    req_i[1] = 1'b1; addr_i[1] = 24'hFFF000;
    #(CLK_P/4);
    chk(ext_sel_o[1] == 1'b1, "R1", "window external after 000", ext_sel_o[1], 1);
    @(negedge clk);
    req_i[1] = 1'b0;
    set_mode(1'b0);
    @(negedge clk);
    rd_run(1, 24'hFFFFFE, 1, 1'b0, 3, "R3");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule